// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh and Parity

This block sits between a simple host request port and a bank of nine 64K x 1 asynchronous dynamic memory devices. Eight devices hold the bits of each byte and the ninth holds an even-parity bit. A host request carries a write flag, a 16-bit address and a byte of write data. The controller splits the address into a row half and a column half and places them on one 8-bit pin bus, one after the other. It orders the active-low row strobe, column strobe and write-enable for each kind of cycle. It returns the read byte together with a one-cycle completion pulse and a parity-error flag.

Stored charge leaks away, so the controller also runs row-strobe-only refresh cycles on its own. A pacing timer divides the refresh interval, given in clocks, by the number of rows. It raises one refresh request per slice, and an 8-bit row counter walks through every row. A pending refresh wins over a waiting host request at the next idle point. A host cycle that has already begun always runs to completion. Every strobe timing (precharge, row-to-column delay, column pulse width) is a whole number of clocks taken from parameters.

Top module: `adram_ctrl`

## Requirements
- R1: A read keeps write-enable high. `req_addr[7:0]` is on `mem_addr` for at least one clock before the row strobe falls. `req_addr[15:8]` is on `mem_addr` for at least one clock after the row strobe is low and before the column strobe falls. The byte stored at that address appears on `rsp_rdata` in the cycle `rsp_done` is high.
- R2: A write drives write-enable low at least one clock before the row strobe falls and holds it steady while the row strobe is low. The column strobe falls while `mem_din` holds the word to store. All three strobes then return high together.
- R3: A refresh cycle keeps the column strobe high throughout. It holds the row strobe low for exactly T_RCD + 1 + T_CAS clocks, with the refresh row on `mem_addr`.
- R4: The refresh row starts at 0 after reset and rises by one on each refresh cycle, wrapping from 255 to 0.
- R5: A refresh request is raised every INTERVAL_CLKS / 256 clocks. Successive refresh cycles are never further apart than that slice plus the length of one host cycle and one idle clock.
- R6: A pending refresh takes priority over a waiting host request, so a host that keeps `req_valid` high without pause does not stop refresh.
- R7: Bit 8 of `mem_din` is the even-parity bit of the write byte on bits 7:0. It is 1 exactly when the byte holds an odd number of ones.
- R8: `rsp_perr` is high only in a read's `rsp_done` cycle, and only when the nine bits sampled from `mem_dout` hold an odd number of ones.
- R9: The column strobe is only low while the row strobe is low. It falls exactly T_RCD + 1 clocks after the row strobe and stays low for exactly T_CAS clocks. The row strobe stays high for at least T_RP clocks between cycles.
- R10: While reset is high, all strobes are high and `rsp_done` and `rsp_perr` are low.
- R11: Each accepted host request completes with exactly one single-cycle `rsp_done` pulse, and a begun host cycle always asserts its column strobe before the row strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request; held with its fields until `rsp_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address (low half = row, high half = column) |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_perr | output | 1 | Parity error on the completing read |
| mem_addr | output | 8 | Multiplexed row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 9 | Data into the nine devices (bit 8 = parity) |
| mem_dout | input | 9 | Data out of the nine devices (bit 8 = parity) |

## Verification
The bench builds the controller with T_RP = 2, T_RCD = 2, T_CAS = 1 and INTERVAL_CLKS = 10240. That gives a refresh slice of 40 clocks, so a full 256-row sweep and its wrap to row 0 fit in about ten thousand clocks. The short strobe counts let a stream of back-to-back host reads keep the controller busy most of the time. This shows refresh still gets in under steady traffic. The bench also injects single-bit faults into its memory model's data and parity bits to exercise the error flag.

// File: rtl/adram_pkg.sv
package adram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_REFRESH
    } op_kind_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic odd_ones(input logic [63:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/adram_parity.sv
module adram_parity
    import adram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W:0]   wr_word,
    input  logic [DATA_W:0]   rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    always_comb begin
        wr_word = {odd_ones(64'(wr_data)), wr_data};
        rd_data = rd_word[DATA_W-1:0];
        rd_err  = odd_ones(64'(rd_word));
    end
endmodule

// File: rtl/adram_refresh_pacer.sv
module adram_refresh_pacer #(
    parameter int ROW_W         = 8,
    parameter int INTERVAL_CLKS = 200000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int ROWS   = 2 ** ROW_W;
    localparam int PERIOD = (INTERVAL_CLKS / ROWS < 2) ? 2 : INTERVAL_CLKS / ROWS;
    localparam int TCW    = $clog2(PERIOD);

    logic [TCW-1:0] tick_cnt;
    logic           tick;

    assign tick = (tick_cnt == TCW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            row     <= '0;
        end else begin
            if (tick) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
            if (ack) begin
                row <= row + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adram_sequencer.sv
module adram_sequencer
    import adram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W:0]     req_word,
    input  logic                ref_pending,
    input  logic [ADDR_W/2-1:0] ref_row,
    output logic                ref_ack,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                rd_err,
    output logic [ADDR_W/2-1:0] mem_addr,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [DATA_W:0]     mem_din,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_perr
);
    localparam int PIN_W = ADDR_W / 2;
    localparam int CNT_W = bits_for(max3(T_RCD, T_CAS, T_RP));

    seq_state_t        state;
    op_kind_t          kind;
    logic [CNT_W-1:0]  cnt;
    logic [PIN_W-1:0]  row_q;
    logic [PIN_W-1:0]  col_q;
    logic [DATA_W:0]   word_q;
    logic              start_ref;
    logic              start_host;
    logic              ras_on;
    logic              is_ref;

    always_comb begin
        start_ref  = (state == ST_IDLE) && ref_pending;
        start_host = (state == ST_IDLE) && !ref_pending && req_valid;
        ref_ack    = start_ref;
        is_ref     = (kind == OP_REFRESH);
        ras_on     = (state == ST_RAS) || (state == ST_COL) || (state == ST_CAS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= OP_READ;
            cnt   <= '0;
            row_q <= '0;
            col_q <= '0;
            word_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ref) begin
                        kind  <= OP_REFRESH;
                        row_q <= ref_row;
                        state <= ST_ROW;
                    end else if (start_host) begin
                        kind   <= req_write ? OP_WRITE : OP_READ;
                        row_q  <= req_addr[PIN_W-1:0];
                        col_q  <= req_addr[ADDR_W-1:PIN_W];
                        word_q <= req_word;
                        state  <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    cnt   <= CNT_W'(T_RCD - 1);
                    state <= ST_RAS;
                end
                ST_RAS: begin
                    if (cnt == '0) begin
                        state <= ST_COL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    cnt   <= CNT_W'(T_CAS - 1);
                    state <= ST_CAS;
                end
                ST_CAS: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_W'(T_RP - 1);
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion and read capture at the end of the last column-strobe clock
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_perr  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_perr <= 1'b0;
            if (state == ST_CAS && cnt == '0 && !is_ref) begin
                rsp_done <= 1'b1;
                if (kind == OP_READ) begin
                    rsp_rdata <= rd_data;
                    rsp_perr  <= rd_err;
                end
            end
        end
    end

    always_comb begin
        ras_n   = !ras_on;
        cas_n   = !((state == ST_CAS) && !is_ref);
        we_n    = !((kind == OP_WRITE) && (ras_on || state == ST_ROW));
        mem_din = word_q;
        if ((state == ST_COL || state == ST_CAS) && !is_ref) begin
            mem_addr = col_q;
        end else begin
            mem_addr = row_q;
        end
    end
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
    import adram_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int T_RCD         = 2,
    parameter int T_CAS         = 2,
    parameter int T_RP          = 3,
    parameter int INTERVAL_CLKS = 200000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done,
    output logic                rsp_perr,
    output logic [ADDR_W/2-1:0] mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic [DATA_W:0]     mem_din,
    input  logic [DATA_W:0]     mem_dout
);
    localparam int PIN_W = ADDR_W / 2;

    logic [DATA_W:0]   wr_word;
    logic [DATA_W-1:0] rd_data;
    logic              rd_err;
    logic              ref_pending;
    logic              ref_ack;
    logic [PIN_W-1:0]  ref_row;

    adram_parity #(.DATA_W(DATA_W)) u_parity (
        .wr_data (req_wdata),
        .wr_word (wr_word),
        .rd_word (mem_dout),
        .rd_data (rd_data),
        .rd_err  (rd_err)
    );

    adram_refresh_pacer #(
        .ROW_W         (PIN_W),
        .INTERVAL_CLKS (INTERVAL_CLKS)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    adram_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .T_RCD  (T_RCD),
        .T_CAS  (T_CAS),
        .T_RP   (T_RP)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_word    (wr_word),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_ack     (ref_ack),
        .rd_data     (rd_data),
        .rd_err      (rd_err),
        .mem_addr    (mem_addr),
        .ras_n       (mem_ras_n),
        .cas_n       (mem_cas_n),
        .we_n        (mem_we_n),
        .mem_din     (mem_din),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .rsp_perr    (rsp_perr)
    );
endmodule

// File: rtl/adram_ctrl_checks.sv
module adram_ctrl_checks #(
    parameter int PIN_W = 8,
    parameter int T_RP  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [PIN_W-1:0] mem_addr,
    input logic             mem_ras_n,
    input logic             mem_cas_n,
    input logic             mem_we_n,
    input logic             rsp_done,
    input logic             rsp_perr
);
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= T_RP;
        end else if (!mem_ras_n) begin
            hi_cnt <= 0;
        end else if (hi_cnt < T_RP) begin
            hi_cnt <= hi_cnt + 1;
        end
    end

    a_r9_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> !mem_ras_n);

    a_r9_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ras_n) |-> (hi_cnt >= T_RP));

    a_r2_we_steady: assert property (@(posedge clk) disable iff (rst)
        (!mem_ras_n && $past(!mem_ras_n)) |-> $stable(mem_we_n));

    a_r1_row_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ras_n) |-> $stable(mem_addr));

    a_r1_col_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cas_n) |-> ($stable(mem_addr) && $past(!mem_ras_n)));

    a_r8_perr_with_done: assert property (@(posedge clk) disable iff (rst)
        rsp_perr |-> rsp_done);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (mem_ras_n && mem_cas_n && !rsp_done && !rsp_perr));
endmodule

bind adram_ctrl adram_ctrl_checks #(.PIN_W(ADDR_W / 2), .T_RP(T_RP)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .rsp_done  (rsp_done),
    .rsp_perr  (rsp_perr)
);

// File: tb/adram_ctrl_bench.sv
module adram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_RP       = 2;
    localparam int T_RCD      = 2;
    localparam int T_CAS      = 1;
    localparam int INTERVAL   = 10240;
    localparam int SLICE      = INTERVAL / 256;
    localparam int HOST_LEN   = 1 + T_RCD + 1 + T_CAS + T_RP;
    localparam int GAP_MAX    = SLICE + HOST_LEN + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        rsp_perr;
    logic [7:0]  mem_addr;
    logic        mem_ras_n;
    logic        mem_cas_n;
    logic        mem_we_n;
    logic [8:0]  mem_din;
    logic [8:0]  mem_dout = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int done_count = 0;
    int ref_count  = 0;

    logic [8:0] model [logic [15:0]];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adram_ctrl #(
        .ADDR_W(16), .DATA_W(8), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RP(T_RP), .INTERVAL_CLKS(INTERVAL)
    ) u_adram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_perr(rsp_perr), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_din(mem_din), .mem_dout(mem_dout)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Device model and strobe protocol monitor, sampled mid-cycle
    logic       prev_ras, prev_cas, prev_we, ras_we, cas_seen;
    logic [7:0] prev_addr, row_lat, exp_row;
    int         low_cnt, cas_cnt, high_cnt, last_ref;

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 1'b1; prev_cas = 1'b1; prev_we = 1'b1;
            prev_addr = mem_addr; exp_row = '0;
            low_cnt = 0; cas_cnt = 0; high_cnt = T_RP; last_ref = cyc;
            cas_seen = 1'b0; ras_we = 1'b1; row_lat = '0;
        end else begin
            if (rsp_done) done_count++;
            if (!mem_cas_n && mem_ras_n) check(0, "R9 cas without ras", 1, 0);
            if (mem_cas_n && !prev_cas) check(cas_cnt == T_CAS, "R9 cas width", cas_cnt, T_CAS);
            if (mem_ras_n && !prev_ras && !cas_seen) begin
                check(low_cnt == T_RCD + 1 + T_CAS, "R3 refresh ras width", low_cnt, T_RCD + 1 + T_CAS);
                check(row_lat == exp_row, "R4 refresh row", row_lat, exp_row);
                check(cyc - last_ref <= GAP_MAX, "R5 refresh gap", cyc - last_ref, GAP_MAX);
                exp_row = exp_row + 8'd1;
                ref_count++;
                last_ref = cyc;
            end
            if (!mem_ras_n && prev_ras) begin
                check(mem_addr == prev_addr, "R1 row setup", mem_addr, prev_addr);
                check(high_cnt >= T_RP, "R9 precharge", high_cnt, T_RP);
                if (!mem_we_n) check(!prev_we, "R2 we before ras", prev_we, 0);
                ras_we = mem_we_n; low_cnt = 0; cas_seen = 1'b0; row_lat = mem_addr;
            end
            if (!mem_ras_n) begin
                high_cnt = 0;
                if (mem_we_n !== ras_we) check(0, "R2 we steady", mem_we_n, ras_we);
                if (!mem_cas_n && prev_cas) begin
                    check(low_cnt == T_RCD + 1, "R9 ras to cas", low_cnt, T_RCD + 1);
                    check(mem_addr == prev_addr, "R1 col setup", mem_addr, prev_addr);
                    cas_seen = 1'b1; cas_cnt = 0;
                    if (!mem_we_n) model[{mem_addr, row_lat}] = mem_din;
                    else mem_dout = model.exists({mem_addr, row_lat}) ? model[{mem_addr, row_lat}] : 9'h0;
                end
                if (!mem_cas_n) cas_cnt++;
                low_cnt++;
            end else begin
                high_cnt++;
            end
            prev_ras = mem_ras_n; prev_cas = mem_cas_n; prev_we = mem_we_n; prev_addr = mem_addr;
        end
    end

    task automatic wait_done(input string tag);
        int n = 0;
        while (!rsp_done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(rsp_done, tag, rsp_done, 1);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        wait_done("R11 write done");
        req_valid = 1'b0;
        check(model.exists(a) && model[a] == {^d, d}, "R2 R7 stored word",
              model.exists(a) ? model[a] : 9'h1ff, {^d, d});
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] exp_d, input bit exp_err);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        wait_done("R11 read done");
        req_valid = 1'b0;
        check(rsp_rdata == exp_d, "R1 read data", rsp_rdata, exp_d);
        check(rsp_perr == exp_err, "R8 parity flag", rsp_perr, exp_err);
    endtask

    task automatic test_reset();
        check(mem_ras_n && mem_cas_n && mem_we_n, "R10 strobes high in reset",
              {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
        check(!rsp_done && !rsp_perr, "R10 no response in reset", {rsp_done, rsp_perr}, 0);
    endtask

    task automatic test_patterns();
        do_write(16'h0000, 8'h00);
        do_write(16'hFFFF, 8'hFF);
        do_write(16'h1234, 8'h01);
        do_write(16'hA55A, 8'h80);
        do_write(16'h00FF, 8'h7E);
        do_write(16'hFF00, 8'h13);
        do_read(16'h0000, 8'h00, 0);
        do_read(16'hFFFF, 8'hFF, 0);
        do_read(16'h1234, 8'h01, 0);
        do_read(16'hA55A, 8'h80, 0);
        do_read(16'h00FF, 8'h7E, 0);
        do_read(16'hFF00, 8'h13, 0);
        do_read(16'h4321, 8'h00, 0);
        do_write(16'h1234, 8'hC3);
        do_read(16'h1234, 8'hC3, 0);
    endtask

    task automatic test_parity_faults();
        model[16'h1234] = model[16'h1234] ^ 9'h008;
        do_read(16'h1234, 8'hCB, 1);
        model[16'hA55A] = model[16'hA55A] ^ 9'h100;
        do_read(16'hA55A, 8'h80, 1);
        model[16'h00FF] = model[16'h00FF] ^ 9'h003;
        do_read(16'h00FF, 8'h7D, 0);
    endtask

    task automatic test_streaming();
        int start_cyc, start_ref, start_done, want;
        start_cyc = cyc; start_ref = ref_count; start_done = done_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        for (int i = 0; i < 250; i++) begin
            req_addr = 16'h0000;
            @(negedge clk);
            wait_done("R11 stream done");
            check(rsp_rdata == 8'h00, "R1 stream data", rsp_rdata, 0);
        end
        req_valid = 1'b0;
        want = (cyc - start_cyc) / GAP_MAX - 1;
        check(ref_count - start_ref >= want, "R6 refresh under load", ref_count - start_ref, want);
        check(done_count - start_done == 250, "R11 one done per request", done_count - start_done, 250);
    endtask

    task automatic test_sweep();
        int start_ref;
        start_ref = ref_count;
        repeat (257 * SLICE + 20) @(negedge clk);
        check(ref_count - start_ref >= 256, "R4 R5 full row sweep", ref_count - start_ref, 256);
        check(ref_count >= 256, "R4 row counter wrapped", ref_count, 256);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_patterns();
        test_parity_faults();
        test_streaming();
        test_sweep();
        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule